// File: doc/BRIEF.md
# Range Up-Counter with Overflow Lookahead

This block is a synchronous up-counter that visits every integer in an inclusive window, from a low bound to a high bound. It advances one step per cycle while an increment strobe is high. A clear strobe sends it back to the low bound. After the high bound, the next increment takes it back to the low bound rather than to zero.

Besides the registered count, the block outputs the value the register will take at the next edge. This lets a neighbour act on the coming state in the current cycle. Two flags look ahead to the wrap:
- one reports that a wrap happens at this edge;
- the other reports that a wrap would happen if an increment were requested now.

A mode parameter picks how the window is given:
- an explicit low and high bound;
- a number of states starting at zero;
- a bit count covering the whole power-of-two range.

A free-run parameter ignores the strobe and advances every cycle. The register is exactly as wide as the high bound needs.

Top module: `rng_counter`

## Requirements
- R1: A synchronous active-high reset loads the low bound into the count (2 in the default explicit mode, 0 in the state-count and bit-count modes).
- R2: While clear is low and the count is below the high bound, an increment adds one at the next edge. With neither increment nor clear, the count holds. The count never leaves the window.
- R3: When the count equals the high bound and an increment is taken, the count equals the low bound after the next edge.
- R4: Clear loads the low bound at the next edge and wins over a simultaneous increment.
- R5: `value_next` always equals the value that `value` shows after the next edge.
- R6: `will_overflow` is 1 exactly when the count is at the high bound, an increment is taken and clear is low.
- R7: `will_overflow_if_inc` is 1 exactly when the count is at the high bound, whatever the strobes are.
- R8: The width of `value` is the smallest that holds the high bound (4 bits for the default window 2..9).
- R9: In state-count mode with N states, the counter steps through 0..N-1 and then returns to 0.
- R10: In bit-count mode with B bits, the counter steps through 0..2^B-1 and then returns to 0.
- R11: With free-run set, the counter advances every cycle and the increment input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inc | input | 1 | Increment strobe (ignored in free-run) |
| clear | input | 1 | Return-to-low-bound strobe |
| value | output | W | Registered count |
| value_next | output | W | Count after the coming edge |
| will_overflow | output | 1 | Wrap happens at the coming edge |
| will_overflow_if_inc | output | 1 | Count sits at the high bound |

## Verification
Clear and increment can both be requested in the same cycle. The collision that matters most is the one at the high bound, where a taken increment would wrap. The bench raises both strobes once mid-window and once with the count at the high bound. It then judges three things:
- `value_next` shows the low bound;
- `will_overflow` stays low while `will_overflow_if_inc` stays high;
- the register holds the low bound after the edge.

// File: rtl/rngcnt_pkg.sv
package rngcnt_pkg;

  typedef enum logic [1:0] {
    MODE_RANGE,
    MODE_STATES,
    MODE_BITS
  } cntMode_e;

  typedef struct packed {
    logic doClear;
    logic doInc;
    logic doWrap;
  } cntStrobe_t;

  function automatic int widthFor(input int hiBound);
    return (hiBound < 2) ? 1 : $clog2(hiBound + 1);
  endfunction

endpackage

// File: rtl/rng_counter_ctrl.sv
module rng_counter_ctrl
  import rngcnt_pkg::*;
#(
  parameter bit FREE_RUN = 1'b0
) (
  input  logic       inc,
  input  logic       clear,
  input  logic       atEnd,
  output cntStrobe_t strobe,
  output logic       willOverflow,
  output logic       willOverflowIfInc
);

  logic incReq;

  generate
    if (FREE_RUN) begin : g_free
      logic unusedInc;
      assign unusedInc = inc;
      assign incReq    = 1'b1;
    end else begin : g_strobe
      assign incReq = inc;
    end
  endgenerate

  always_comb begin
    strobe.doClear = clear;
    strobe.doInc   = incReq && !clear;
    strobe.doWrap  = incReq && !clear && atEnd;
  end

  assign willOverflow      = strobe.doWrap;
  assign willOverflowIfInc = atEnd;

endmodule

// File: rtl/rng_counter_dp.sv
module rng_counter_dp
  import rngcnt_pkg::*;
#(
  parameter int W  = 4,
  parameter int LO = 2,
  parameter int HI = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  cntStrobe_t   strobe,
  output logic [W-1:0] valueQ,
  output logic [W-1:0] valueNext,
  output logic         atEnd
);

  localparam logic [W-1:0] LoVal = W'(LO);
  localparam logic [W-1:0] HiVal = W'(HI);

  assign atEnd = (valueQ == HiVal);

  always_comb begin
    valueNext = valueQ;
    if (strobe.doClear) begin
      valueNext = LoVal;
    end else if (strobe.doInc) begin
      valueNext = strobe.doWrap ? LoVal : valueQ + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valueQ <= LoVal;
    end else begin
      valueQ <= valueNext;
    end
  end

endmodule

// File: rtl/rng_counter.sv
module rng_counter
  import rngcnt_pkg::*;
#(
  parameter cntMode_e MODE        = MODE_RANGE,
  parameter int       START       = 2,
  parameter int       END         = 9,
  parameter int       STATE_COUNT = 8,
  parameter int       BIT_COUNT   = 3,
  parameter bit       FREE_RUN    = 1'b0,
  localparam int      LO = (MODE == MODE_RANGE) ? START : 0,
  localparam int      HI = (MODE == MODE_RANGE)  ? END :
                           (MODE == MODE_STATES) ? STATE_COUNT - 1 :
                                                   (1 << BIT_COUNT) - 1,
  localparam int      W  = widthFor(HI)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clear,
  output logic [W-1:0] value,
  output logic [W-1:0] value_next,
  output logic         will_overflow,
  output logic         will_overflow_if_inc
);

  cntStrobe_t strobe;
  logic       atEnd;

  rng_counter_ctrl #(
    .FREE_RUN(FREE_RUN)
  ) u_ctrl (
    .inc              (inc),
    .clear            (clear),
    .atEnd            (atEnd),
    .strobe           (strobe),
    .willOverflow     (will_overflow),
    .willOverflowIfInc(will_overflow_if_inc)
  );

  rng_counter_dp #(
    .W (W),
    .LO(LO),
    .HI(HI)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .valueQ   (value),
    .valueNext(value_next),
    .atEnd    (atEnd)
  );

endmodule

// File: rtl/rng_counter_chk.sv
module rng_counter_chk #(
  parameter int W        = 4,
  parameter int LO       = 2,
  parameter int HI       = 9,
  parameter bit FREE_RUN = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         inc,
  input logic         clear,
  input logic [W-1:0] value,
  input logic [W-1:0] value_next,
  input logic         will_overflow,
  input logic         will_overflow_if_inc
);

  logic incTaken;
  assign incTaken = inc || FREE_RUN;

  AST_RESET_LOAD: assert property (@(posedge clk) rst |=> int'(value) == LO); // R1

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (int'(value) >= LO) && (int'(value) <= HI)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clear && !incTaken) |=> $stable(value)); // R2

  AST_WRAP_START: assert property (@(posedge clk) disable iff (rst)
    will_overflow |=> int'(value) == LO); // R3

  AST_CLEAR_START: assert property (@(posedge clk) disable iff (rst)
    clear |=> int'(value) == LO); // R4

  AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> value == $past(value_next)); // R5

  AST_OVF_NEEDS_INC: assert property (@(posedge clk) disable iff (rst)
    will_overflow |-> (incTaken && !clear && will_overflow_if_inc)); // R6

  AST_IFINC_AT_END: assert property (@(posedge clk) disable iff (rst)
    will_overflow_if_inc |-> int'(value) == HI); // R7

endmodule

bind rng_counter rng_counter_chk #(
  .W(W), .LO(LO), .HI(HI), .FREE_RUN(FREE_RUN)
) u_chk (.*);

// File: tb/rng_counter_tb.sv
`timescale 1ns/1ps
module rng_counter_tb;
  import rngcnt_pkg::*;

  logic clk = 1'b0;
  logic rst, inc, clear, sInc;
  logic [3:0] dVal, dNext;
  logic       dOvf, dIfInc;
  logic [2:0] sVal, sNext, fVal, fNext;
  logic       sOvf, sIfInc, fOvf, fIfInc;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rng_counter u_dut (
    .clk(clk), .rst(rst), .inc(inc), .clear(clear),
    .value(dVal), .value_next(dNext),
    .will_overflow(dOvf), .will_overflow_if_inc(dIfInc)
  );

  rng_counter #(.MODE(MODE_STATES), .STATE_COUNT(5)) u_states (
    .clk(clk), .rst(rst), .inc(sInc), .clear(1'b0),
    .value(sVal), .value_next(sNext),
    .will_overflow(sOvf), .will_overflow_if_inc(sIfInc)
  );

  rng_counter #(.MODE(MODE_BITS), .BIT_COUNT(3), .FREE_RUN(1'b1)) u_free (
    .clk(clk), .rst(rst), .inc(1'b0), .clear(1'b0),
    .value(fVal), .value_next(fNext),
    .will_overflow(fOvf), .will_overflow_if_inc(fIfInc)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1; inc = 1'b0; clear = 1'b0; sInc = 1'b0;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    check("R1 range low bound", int'(dVal), 2);
    check("R1 states low bound", int'(sVal), 0);
    check("R1 bits low bound", int'(fVal), 0);
    check("R7 not at end after reset", int'(dIfInc), 0);
  endtask

  task automatic t_step();
    doReset();
    inc = 1'b1;
    for (int i = 2; i <= 9; i++) begin
      #0.5;
      check("R5 next during step", int'(dNext), (i == 9) ? 2 : i + 1);
      check("R6 overflow flag", int'(dOvf), (i == 9) ? 1 : 0);
      check("R7 lookahead flag", int'(dIfInc), (i == 9) ? 1 : 0);
      cyc();
      check((i == 9) ? "R3 wrap to low bound" : "R2 step by one",
            int'(dVal), (i == 9) ? 2 : i + 1);
    end
    inc = 1'b0;
  endtask

  task automatic t_hold();
    doReset();
    for (int i = 0; i < 3; i++) begin
      cyc();
      check("R2 hold without inc", int'(dVal), 2);
    end
    inc = 1'b1;
    for (int i = 0; i < 7; i++) cyc();
    inc = 1'b0;
    #0.5;
    check("R7 flag at end without inc", int'(dIfInc), 1);
    check("R6 no overflow without inc", int'(dOvf), 0);
    check("R5 next equals held value", int'(dNext), 9);
    cyc();
    check("R2 hold at high bound", int'(dVal), 9);
  endtask

  task automatic t_clear();
    doReset();
    inc = 1'b1;
    for (int i = 0; i < 3; i++) cyc();
    check("R2 reached 5", int'(dVal), 5);
    clear = 1'b1;
    #0.5;
    check("R4 next is low bound mid-window", int'(dNext), 2);
    check("R6 no overflow mid-window", int'(dOvf), 0);
    cyc();
    check("R4 clear beats inc", int'(dVal), 2);
    clear = 1'b0;
    for (int i = 0; i < 7; i++) cyc();
    check("R2 reached high bound", int'(dVal), 9);
    clear = 1'b1;
    #0.5;
    check("R6 clear suppresses overflow", int'(dOvf), 0);
    check("R7 lookahead with clear", int'(dIfInc), 1);
    cyc();
    check("R4 clear at high bound", int'(dVal), 2);
    clear = 1'b0;
    inc = 1'b0;
  endtask

  task automatic t_width();
    check("R8 range width", $bits(u_dut.value), 4);
    check("R8 states width", $bits(u_states.value), 3);
  endtask

  task automatic t_states();
    doReset();
    sInc = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      cyc();
      check("R9 state-count sequence", int'(sVal), k % 5);
    end
    sInc = 1'b0;
    cyc();
    check("R9 state-count hold", int'(sVal), 2);
  endtask

  task automatic t_free();
    doReset();
    for (int k = 1; k <= 12; k++) begin
      cyc();
      check("R10 R11 free-running bits sequence", int'(fVal), k % 8);
      check("R11 free-run overflow", int'(fOvf), (k % 8 == 7) ? 1 : 0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; inc = 1'b0; clear = 1'b0; sInc = 1'b0;
    t_reset();
    t_step();
    t_hold();
    t_clear();
    t_width();
    t_states();
    t_free();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule